// File: doc/BRIEF.md
# Transaction Read/Write Signature Filter

This block keeps a compact, conservative record of which memory blocks a running transaction has read and which it has written. Each set is a Bloom-filter signature that sits beside the caches rather than inside them. Software instrumentation pushes physical addresses into the block through an insert port, marking each address as a read or a write. The low offset bits are discarded first, so all addresses inside one cache block share an entry.

A snoop port watches coherence requests from other agents. When a request asks for exclusive ownership of a block, the snooped address is looked up in both signatures. Exclusive ownership requests are the only ones that imply a remote update. If the address may be present, the matching conflict flag is raised one cycle later. Shared reads and eviction notices are never tested, so local capacity and conflict misses cannot produce a conflict. Aliasing inside a filter may report a conflict that did not happen, but an address that was inserted is never missed. A clear input empties both signatures at the start of a new transaction.

Top module: `tsig_unit`

## Requirements
- R1: After reset both signatures are empty: no exclusive snoop raises `hit_rd` or `hit_wr`, and both flags are low.
- R2: An insert with `ins_is_write`=0 marks the read signature only. A later exclusive snoop of the same block raises `hit_rd`, and it does not raise `hit_wr` unless the write signature also holds that block.
- R3: An insert with `ins_is_write`=1 marks the write signature only. A later exclusive snoop of that block raises `hit_wr`.
- R4: `snoop_type` encodes 0 = shared read, 1 = read for ownership, 2 = upgrade to exclusive, 3 = eviction notice. Only types 1 and 2 are tested. Types 0 and 3 never raise a flag.
- R5: `hit_rd` and `hit_wr` are registered. They show the lookup of the cycle in which `snoop_valid` was high, one clock later, for one cycle only. They are low in any cycle not preceded by a valid snoop.
- R6: Addresses are reduced to block addresses by dropping the low 6 bits. Addresses that differ only in those bits behave identically.
- R7: No false negatives: every block inserted since the last clear hits its signature, however many inserts have followed.
- R8: A filter reports a hit exactly when all 3 of its bits chosen by the hashes are set. This allows aliased hits. Hash k (k = 0, 1, 2) rotates the 34-bit block address left by (11*k) mod 34 bits, zero-extends it to 36 bits and XORs its four 9-bit slices into an index into 512 bits.
- R9: `clear` empties both signatures. An insert presented in the same cycle as `clear` is dropped.
- R10: A lookup sees the signature contents from before any insert or clear presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clear | input | 1 | Empty both signatures |
| ins_valid | input | 1 | Insert request |
| ins_is_write | input | 1 | 1 = write set, 0 = read set |
| ins_addr | input | 40 | Physical address to insert |
| snoop_valid | input | 1 | Snooped coherence request present |
| snoop_type | input | 2 | Request kind (see R4) |
| snoop_addr | input | 40 | Physical address of the snooped request |
| hit_rd | output | 1 | Snoop conflicts with the read signature |
| hit_wr | output | 1 | Snoop conflicts with the write signature |

## Verification
The bench keeps its own pair of 512-bit images, built from the stated hash, and predicts each flag exactly. A design that lost a bit, mixed up the two sets or hashed differently would show up either as a missed conflict after many inserts or as a disagreement on a deliberately aliased address. Shared-read and eviction snoops are sent against populated filters; a design that tested every request type would report conflicts on plain misses. Inserts and clears are also placed in the same cycle as a snoop, and an insert in the same cycle as a clear. A design with forwarding, or one that let the insert win over clear, would flag the wrong cycle or keep a stale block.

// File: rtl/tsig_pkg.sv
package tsig_pkg;
  localparam int unsigned DEF_ADDR_W   = 40;
  localparam int unsigned DEF_BLK_OFS  = 6;
  localparam int unsigned DEF_SIG_BITS = 512;
  localparam int unsigned DEF_NUM_HASH = 3;
  localparam int unsigned DEF_ROT_STEP = 11;

  typedef enum logic [1:0] {
    SNP_SHARED  = 2'd0,
    SNP_OWN     = 2'd1,
    SNP_UPGRADE = 2'd2,
    SNP_EVICT   = 2'd3
  } snoop_kind_e;

  // requests that imply a remote update of the block
  function automatic logic wants_exclusive(input logic [1:0] kind);
    return (kind == SNP_OWN) || (kind == SNP_UPGRADE);
  endfunction
endpackage

// File: rtl/tsig_rst_sync.sv
module tsig_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_out_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_out_n = stage_q[1];
endmodule

// File: rtl/tsig_hash.sv
module tsig_hash #(
  parameter int unsigned ADDR_W   = 40,
  parameter int unsigned BLK_OFS  = 6,
  parameter int unsigned IDX_W    = 9,
  parameter int unsigned NUM_HASH = 3,
  parameter int unsigned ROT_STEP = 11
) (
  input  logic [ADDR_W-1:0]                 addr,
  output logic [NUM_HASH-1:0][IDX_W-1:0]    idx
);
  localparam int unsigned BA_W   = ADDR_W - BLK_OFS;
  localparam int unsigned NCHUNK = (BA_W + IDX_W - 1) / IDX_W;
  localparam int unsigned PAD_W  = NCHUNK * IDX_W;

  logic [BA_W-1:0] blk;
  assign blk = addr[ADDR_W-1:BLK_OFS];

  for (genvar k = 0; k < NUM_HASH; k++) begin : g_hash
    localparam int unsigned SH = (ROT_STEP * k) % BA_W;
    logic [2*BA_W-1:0] dbl;
    logic [BA_W-1:0]   rot;
    logic [PAD_W-1:0]  pad;
    logic [IDX_W-1:0]  acc;

    assign dbl = {blk, blk} << SH;
    assign rot = dbl[2*BA_W-1:BA_W];
    assign pad = PAD_W'(rot);

    always_comb begin
      acc = '0;
      for (int c = 0; c < NCHUNK; c++) acc = acc ^ pad[c*IDX_W +: IDX_W];
    end

    assign idx[k] = acc;
  end
endmodule

// File: rtl/tsig_filter.sv
module tsig_filter #(
  parameter int unsigned SIG_BITS = 512,
  parameter int unsigned NUM_HASH = 3,
  parameter int unsigned IDX_W    = $clog2(SIG_BITS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          ins_en,
  input  logic [NUM_HASH-1:0][IDX_W-1:0] ins_idx,
  input  logic [NUM_HASH-1:0][IDX_W-1:0] probe_idx,
  output logic                          present
);
  logic [SIG_BITS-1:0] bits_q, bits_d;
  logic                bits_en;

  // next state: clear wins over a same-cycle insert
  always_comb begin
    bits_d = bits_q;
    if (clear) begin
      bits_d = '0;
    end else if (ins_en) begin
      for (int k = 0; k < NUM_HASH; k++) bits_d[ins_idx[k]] = 1'b1;
    end
  end

  assign bits_en = clear | ins_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bits_q <= '0;
    else if (bits_en) bits_q <= bits_d;
  end

  // lookup against registered contents only
  always_comb begin
    present = 1'b1;
    for (int k = 0; k < NUM_HASH; k++) present = present & bits_q[probe_idx[k]];
  end
endmodule

// File: rtl/tsig_unit.sv
module tsig_unit
  import tsig_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned BLK_OFS  = DEF_BLK_OFS,
  parameter int unsigned SIG_BITS = DEF_SIG_BITS,
  parameter int unsigned NUM_HASH = DEF_NUM_HASH,
  parameter int unsigned ROT_STEP = DEF_ROT_STEP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              ins_valid,
  input  logic              ins_is_write,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_type,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              hit_rd,
  output logic              hit_wr
);
  localparam int unsigned IDX_W = $clog2(SIG_BITS);
  localparam int unsigned NSIG  = 2;   // 0 = read set, 1 = write set

  logic rst_int_n;

  tsig_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_out_n (rst_int_n)
  );

  logic [NUM_HASH-1:0][IDX_W-1:0] ins_idx, snp_idx;

  tsig_hash #(
    .ADDR_W(ADDR_W), .BLK_OFS(BLK_OFS), .IDX_W(IDX_W),
    .NUM_HASH(NUM_HASH), .ROT_STEP(ROT_STEP)
  ) u_hash_ins (
    .addr (ins_addr),
    .idx  (ins_idx)
  );

  tsig_hash #(
    .ADDR_W(ADDR_W), .BLK_OFS(BLK_OFS), .IDX_W(IDX_W),
    .NUM_HASH(NUM_HASH), .ROT_STEP(ROT_STEP)
  ) u_hash_snp (
    .addr (snoop_addr),
    .idx  (snp_idx)
  );

  logic [NSIG-1:0] sig_present;
  logic [NSIG-1:0] sig_ins;

  assign sig_ins[0] = ins_valid & ~ins_is_write;
  assign sig_ins[1] = ins_valid &  ins_is_write;

  for (genvar s = 0; s < NSIG; s++) begin : g_sig
    tsig_filter #(
      .SIG_BITS(SIG_BITS), .NUM_HASH(NUM_HASH), .IDX_W(IDX_W)
    ) u_filter (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .clear     (clear),
      .ins_en    (sig_ins[s]),
      .ins_idx   (ins_idx),
      .probe_idx (snp_idx),
      .present   (sig_present[s])
    );
  end

  logic          probe_on;
  logic [NSIG-1:0] hit_d, hit_q;

  assign probe_on = snoop_valid & wants_exclusive(snoop_type);

  always_comb begin
    hit_d = sig_present & {NSIG{probe_on}};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) hit_q <= '0;
    else            hit_q <= hit_d;
  end

  assign hit_rd = hit_q[0];
  assign hit_wr = hit_q[1];
endmodule

// File: rtl/tsig_unit_chk.sv
module tsig_unit_chk #(
  parameter int unsigned ADDR_W  = 40,
  parameter int unsigned BLK_OFS = 6
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              clear,
  input logic              ins_valid,
  input logic              ins_is_write,
  input logic [ADDR_W-1:0] ins_addr,
  input logic              snoop_valid,
  input logic [1:0]        snoop_type,
  input logic [ADDR_W-1:0] snoop_addr,
  input logic              hit_rd,
  input logic              hit_wr
);
  logic                      last_v_q, last_w_q;
  logic [ADDR_W-BLK_OFS-1:0] last_blk_q;
  logic                      exp_rd_q, exp_wr_q;
  logic                      excl;

  assign excl = (snoop_type == 2'd1) || (snoop_type == 2'd2);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      last_v_q   <= 1'b0;
      last_w_q   <= 1'b0;
      last_blk_q <= '0;
      exp_rd_q   <= 1'b0;
      exp_wr_q   <= 1'b0;
    end else begin
      exp_rd_q <= snoop_valid && excl && last_v_q && !last_w_q &&
                  (snoop_addr[ADDR_W-1:BLK_OFS] == last_blk_q);
      exp_wr_q <= snoop_valid && excl && last_v_q && last_w_q &&
                  (snoop_addr[ADDR_W-1:BLK_OFS] == last_blk_q);
      if (clear) begin
        last_v_q <= 1'b0;
      end else if (ins_valid) begin
        last_v_q   <= 1'b1;
        last_w_q   <= ins_is_write;
        last_blk_q <= ins_addr[ADDR_W-1:BLK_OFS];
      end
    end
  end

  // R5
  flag_needs_snoop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (hit_rd || hit_wr) |-> $past(snoop_valid));

  // R4
  flag_needs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (hit_rd || hit_wr) |-> ($past(snoop_type) == 2'd1 || $past(snoop_type) == 2'd2));

  // R2
  read_insert_seen_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    exp_rd_q |-> hit_rd);

  // R3
  write_insert_seen_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    exp_wr_q |-> hit_wr);

  // R9
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    clear ##1 snoop_valid |=> !(hit_rd || hit_wr));
endmodule

bind tsig_unit tsig_unit_chk #(
  .ADDR_W(ADDR_W), .BLK_OFS(BLK_OFS)
) u_tsig_unit_chk (
  .clk          (clk),
  .rst_int_n    (rst_int_n),
  .clear        (clear),
  .ins_valid    (ins_valid),
  .ins_is_write (ins_is_write),
  .ins_addr     (ins_addr),
  .snoop_valid  (snoop_valid),
  .snoop_type   (snoop_type),
  .snoop_addr   (snoop_addr),
  .hit_rd       (hit_rd),
  .hit_wr       (hit_wr)
);

// File: tb/tsig_unit_bench.sv
module tsig_unit_bench;
  localparam int AW = 40;
  localparam int BA = 34;
  localparam int NB = 512;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clear, ins_valid, ins_is_write, snoop_valid;
  logic [1:0]    snoop_type;
  logic [AW-1:0] ins_addr, snoop_addr;
  logic          hit_rd, hit_wr;

  int checks = 0;
  int fails  = 0;

  bit mrd [NB];
  bit mwr [NB];

  always #4 clk = ~clk;   // 125 MHz

  tsig_unit u_tsig_unit (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .ins_valid(ins_valid), .ins_is_write(ins_is_write), .ins_addr(ins_addr),
    .snoop_valid(snoop_valid), .snoop_type(snoop_type), .snoop_addr(snoop_addr),
    .hit_rd(hit_rd), .hit_wr(hit_wr)
  );

  // hash from the requirement text: bit i of the rotated block feeds index bit i%9
  function automatic int hidx(input logic [AW-1:0] a, input int k);
    logic [BA-1:0] b;
    logic [8:0]    r;
    int            sh;
    b  = a[AW-1:6];
    r  = '0;
    sh = (11 * k) % BA;
    for (int i = 0; i < BA; i++) r[i % 9] = r[i % 9] ^ b[(i - sh + BA) % BA];
    return int'(r);
  endfunction

  function automatic bit in_rd(input logic [AW-1:0] a);
    return mrd[hidx(a,0)] && mrd[hidx(a,1)] && mrd[hidx(a,2)];
  endfunction

  function automatic bit in_wr(input logic [AW-1:0] a);
    return mwr[hidx(a,0)] && mwr[hidx(a,1)] && mwr[hidx(a,2)];
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NB; i++) begin mrd[i] = 1'b0; mwr[i] = 1'b0; end
  endtask

  task automatic model_ins(input logic [AW-1:0] a, input bit w);
    for (int k = 0; k < 3; k++) begin
      if (w) mwr[hidx(a,k)] = 1'b1; else mrd[hidx(a,k)] = 1'b1;
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    clear = 0; ins_valid = 0; ins_is_write = 0; ins_addr = '0;
    snoop_valid = 0; snoop_type = 2'd0; snoop_addr = '0;
  endtask

  task automatic do_ins(input logic [AW-1:0] a, input bit w);
    @(negedge clk);
    idle();
    ins_valid = 1; ins_is_write = w; ins_addr = a;
    model_ins(a, w);
    @(negedge clk);
    idle();
  endtask

  // drive a snoop, compare flags one clock later
  task automatic do_snoop(input logic [AW-1:0] a, input logic [1:0] t,
                          input bit er, input bit ew, input string req);
    @(negedge clk);
    idle();
    snoop_valid = 1; snoop_type = t; snoop_addr = a;
    @(negedge clk);
    idle();
    chk(hit_rd == er, req, hit_rd, er);
    chk(hit_wr == ew, req, hit_wr, ew);
  endtask

  function automatic bit excl(input logic [1:0] t);
    return (t == 2'd1) || (t == 2'd2);
  endfunction

  task automatic snoop_model(input logic [AW-1:0] a, input logic [1:0] t, input string req);
    do_snoop(a, t, excl(t) && in_rd(a), excl(t) && in_wr(a), req);
  endtask

  task automatic t_reset();
    chk(hit_rd == 0 && hit_wr == 0, "R1", {hit_rd, hit_wr}, 0);
    do_snoop(40'h12_3456_7880, 2'd1, 0, 0, "R1");
    do_snoop(40'hFF_FFFF_FFC0, 2'd2, 0, 0, "R1");
  endtask

  task automatic t_read_write();
    do_ins(40'h00_1000_0040, 0);
    snoop_model(40'h00_1000_0040, 2'd1, "R2");
    chk(in_rd(40'h00_1000_0040), "R2", 0, 1);
    do_ins(40'h00_2222_0080, 1);
    snoop_model(40'h00_2222_0080, 2'd2, "R3");
    chk(in_wr(40'h00_2222_0080), "R3", 0, 1);
  endtask

  task automatic t_types();
    snoop_model(40'h00_1000_0040, 2'd0, "R4");
    snoop_model(40'h00_2222_0080, 2'd3, "R4");
    snoop_model(40'h00_2222_0080, 2'd1, "R4");
  endtask

  task automatic t_timing();
    @(negedge clk);
    idle();
    snoop_valid = 1; snoop_type = 2'd1; snoop_addr = 40'h00_1000_0040;
    chk(hit_rd == 0, "R5 before edge", hit_rd, 0);
    @(negedge clk);
    idle();
    chk(hit_rd == 1, "R5 one clock later", hit_rd, 1);
    @(negedge clk);
    chk(hit_rd == 0 && hit_wr == 0, "R5 single cycle", {hit_rd, hit_wr}, 0);
  endtask

  task automatic t_offset();
    do_ins(40'h0A_BCDE_F000, 1);
    for (int o = 0; o < 64; o += 21) snoop_model(40'h0A_BCDE_F000 + AW'(o), 2'd1, "R6");
    do_snoop(40'h0A_BCDE_F03F, 2'd2, in_rd(40'h0A_BCDE_F03F), 1, "R6");
  endtask

  task automatic t_many();
    logic [AW-1:0] a;
    for (int i = 0; i < 60; i++) begin
      a = {AW{1'b0}} | (AW'(i) * 40'h00_0193_4A40) ^ 40'h3C_0000_0000;
      do_ins(a, bit'(i % 2));
    end
    for (int i = 0; i < 60; i++) begin
      a = {AW{1'b0}} | (AW'(i) * 40'h00_0193_4A40) ^ 40'h3C_0000_0000;
      chk((i % 2 == 1) ? in_wr(a) : in_rd(a), "R7 model", 0, 1);
      snoop_model(a, 2'd1, "R7");
    end
  endtask

  task automatic t_alias();
    logic [AW-1:0] a;
    int found = 0;
    for (int c = 1; c < 4000 && found < 2; c++) begin
      a = AW'(c) * 40'h00_7711_03C0;
      if (in_rd(a) || in_wr(a)) begin
        found++;
        snoop_model(a, 2'd2, "R8 aliased");
      end
    end
    chk(found > 0, "R8 alias found", found, 1);
    snoop_model(40'h55_0000_1240, 2'd1, "R8");
    snoop_model(40'h01_2345_6780, 2'd1, "R8");
  endtask

  task automatic t_clear();
    // clear with a same-cycle insert and a same-cycle snoop of a set block
    @(negedge clk);
    idle();
    clear = 1; ins_valid = 1; ins_is_write = 0; ins_addr = 40'h33_3333_3300;
    snoop_valid = 1; snoop_type = 2'd1; snoop_addr = 40'h00_1000_0040;
    @(negedge clk);
    idle();
    chk(hit_rd == 1, "R10 snoop sees pre-clear contents", hit_rd, 1);
    model_clear();
    snoop_model(40'h00_1000_0040, 2'd1, "R9");
    snoop_model(40'h00_2222_0080, 2'd2, "R9");
    do_snoop(40'h33_3333_3300, 2'd1, 0, 0, "R9 dropped insert");
  endtask

  task automatic t_same_cycle_ins();
    @(negedge clk);
    idle();
    ins_valid = 1; ins_is_write = 1; ins_addr = 40'h44_4444_4440;
    snoop_valid = 1; snoop_type = 2'd2; snoop_addr = 40'h44_4444_4440;
    @(negedge clk);
    idle();
    chk(hit_wr == 0, "R10 insert not forwarded", hit_wr, 0);
    model_ins(40'h44_4444_4440, 1);
    snoop_model(40'h44_4444_4440, 2'd2, "R10 visible after");
  endtask

  initial begin
    model_clear();
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read_write();
    t_types();
    t_timing();
    t_offset();
    t_many();
    t_alias();
    t_clear();
    t_same_cycle_ins();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule